// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns a bank of already-synchronized general-purpose input levels into interrupt requests. Software picks a sensing style for each pin through a small byte-wide register port:
- level or edge;
- for edge pins, one edge or both edges;
- the active polarity, shared by both styles.

The block keeps a raw status vector. In edge mode each bit is a sticky latch. In level mode each bit follows the pin directly. The raw status is ANDed with a per-pin enable mask to form a masked status, and a single registered interrupt line reports whether any masked bit is set.

Edge events are found by comparing each pin with its own value one clock earlier. They are recorded whether or not the pin is enabled, so enabling a pin that already holds a pending edge raises the interrupt at once. An edge status bit is cleared only by writing a one to it in the clear register. If a fresh edge and a clear for the same pin land in the same cycle, the edge wins. Level status needs no clearing: it drops as soon as the pin leaves its active level.

Top module: `pin_event_detector`

## Requirements
- R1: While and after reset, the sense, both-edge, polarity and enable registers read 0, the raw and masked status read 0, and irq_o is 0.
- R2: With a pin's sense bit 1 (level), its raw bit equals 1 exactly while the pin equals its polarity bit (1 = high active, 0 = low active). The bit is not held, and it drops in the same cycle the pin leaves that level.
- R3: With sense 0 and both-edge 0, the raw bit becomes 1 after a clock edge at which the pin differs from its previous sampled value in the direction given by the polarity bit (1 = rising, 0 = falling). It then stays 1 until cleared.
- R4: With sense 0 and both-edge 1, a rising or falling pin change sets the raw bit, whatever the polarity bit holds.
- R5: Writing the clear address clears the latched edge status of each pin whose data bit is 1. Pins written with 0 keep their status.
- R6: When a new edge and a clear for the same pin occur in the same cycle, the raw bit is 1 afterwards.
- R7: The masked status equals raw AND enable. Edge events latch even when the pin is disabled, and enabling such a pin exposes the pending bit at once.
- R8: irq_o equals the OR of the masked status one clock earlier (it is driven from a register).
- R9: Register addresses are 0 sense, 1 both-edge, 2 polarity, 3 enable (all read/write), 4 raw status, 5 masked status (read only), and 6 clear (write only). Addresses 6 and 7 read 0. A write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (write and read) |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The two functions that can meet in one cycle are edge capture and the write-one clear of the same status bit. The sweep issues clear writes with pseudo-random masks while pseudo-random pin patterns toggle, under eight different mixes of sense, both-edge and polarity settings, so coincidences arise many times. A directed case also forces a rising edge together with an all-ones clear. Each outcome is judged against an arithmetic model in the bench in which the edge term is ORed after the clear is applied, and the raw, masked and interrupt outputs are compared every cycle.

// File: rtl/ped_pkg.sv
package ped_pkg;
   typedef enum logic [2:0] {
      A_SENSE = 3'd0,
      A_DUAL  = 3'd1,
      A_POL   = 3'd2,
      A_EN    = 3'd3,
      A_RAW   = 3'd4,
      A_MASK  = 3'd5,
      A_CLR   = 3'd6
   } ped_addr_e;
   localparam int ADDR_W = 3;
endpackage

// File: rtl/ped_regfile.sv
module ped_regfile
   import ped_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   input  logic [NUM_PINS-1:0] raw_i,
   input  logic [NUM_PINS-1:0] masked_i,
   output logic [NUM_PINS-1:0] sense_o,
   output logic [NUM_PINS-1:0] dual_o,
   output logic [NUM_PINS-1:0] pol_o,
   output logic [NUM_PINS-1:0] en_o,
   output logic [NUM_PINS-1:0] clr_o,
   output logic [DATA_W-1:0]   rd_data_o
);
   logic [NUM_PINS-1:0] wbits;
   assign wbits = wr_data_i[NUM_PINS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sense_o <= '0;
         dual_o  <= '0;
         pol_o   <= '0;
         en_o    <= '0;
      end else if (wr_en_i) begin
         case (addr_i)
            A_SENSE: sense_o <= wbits;
            A_DUAL:  dual_o  <= wbits;
            A_POL:   pol_o   <= wbits;
            A_EN:    en_o    <= wbits;
            default: ;
         endcase
      end
   end

   assign clr_o = (wr_en_i && addr_i == A_CLR) ? wbits : '0;

   always_comb begin
      case (addr_i)
         A_SENSE: rd_data_o = DATA_W'(sense_o);
         A_DUAL:  rd_data_o = DATA_W'(dual_o);
         A_POL:   rd_data_o = DATA_W'(pol_o);
         A_EN:    rd_data_o = DATA_W'(en_o);
         A_RAW:   rd_data_o = DATA_W'(raw_i);
         A_MASK:  rd_data_o = DATA_W'(masked_i);
         default: rd_data_o = '0;
      endcase
   end

   // R9: an enable write is visible on the next cycle
   p_enable_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == A_EN) |=> (en_o == $past(wbits)));
   // R1: configuration held at zero through reset
   p_reset_cfg_r1: assert property (@(posedge clk)
      !rst_n |=> (sense_o == '0 && en_o == '0 && dual_o == '0 && pol_o == '0));
endmodule

// File: rtl/ped_pin_cell.sv
module ped_pin_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic level_mode_i,
   input  logic dual_i,
   input  logic pol_i,
   input  logic clr_i,
   output logic raw_o
);
   logic pin_q;
   logic lat_q;
   logic rise;
   logic fall;
   logic hit;

   assign rise = pin_i & ~pin_q;
   assign fall = ~pin_i & pin_q;
   assign hit  = ~level_mode_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
         lat_q <= 1'b0;
      end else begin
         pin_q <= pin_i;
         if (level_mode_i) lat_q <= 1'b0;
         else              lat_q <= hit | (lat_q & ~clr_i);
      end
   end

   assign raw_o = level_mode_i ? (pin_i == pol_i) : lat_q;

   // R6: a detected edge always leaves the latch set, clear or not
   p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> lat_q);
   // R5: a clear with no competing edge empties the latch
   p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hit) |=> !lat_q);
   // R3: without edge or clear, an edge-mode latch keeps its value
   p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !clr_i && !level_mode_i) |=> (lat_q == $past(lat_q)));
endmodule

// File: rtl/ped_irq_combine.sv
module ped_irq_combine #(
   parameter int NUM_PINS = 8,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] raw_i,
   input  logic [NUM_PINS-1:0] en_i,
   output logic [NUM_PINS-1:0] masked_o,
   output logic                irq_o
);
   logic any_hit;
   assign masked_o = raw_i & en_i;
   assign any_hit  = |masked_o;

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_hit;
         end
         assign irq_o = irq_q;

         // R8: registered output follows the masked OR with one cycle lag
         p_irq_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == $past(|(raw_i & en_i))));
      end else begin : g_comb
         assign irq_o = any_hit;
      end
   endgenerate
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
   import ped_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int DATA_W   = 8,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic                irq_o
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_cfg
         $error("pin_event_detector: NUM_PINS must lie in 1..DATA_W");
      end
   endgenerate

   logic [NUM_PINS-1:0] sense, dual, pol, en, clr, raw, masked;

   ped_regfile #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .addr_i    (addr_i),
      .wr_data_i (wr_data_i),
      .raw_i     (raw),
      .masked_i  (masked),
      .sense_o   (sense),
      .dual_o    (dual),
      .pol_o     (pol),
      .en_o      (en),
      .clr_o     (clr),
      .rd_data_o (rd_data_o)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      ped_pin_cell u_cell (
         .clk          (clk),
         .rst_n        (rst_n),
         .pin_i        (pin_i[i]),
         .level_mode_i (sense[i]),
         .dual_i       (dual[i]),
         .pol_i        (pol[i]),
         .clr_i        (clr[i]),
         .raw_o        (raw[i])
      );
   end

   ped_irq_combine #(.NUM_PINS(NUM_PINS), .IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (raw),
      .en_i     (en),
      .masked_o (masked),
      .irq_o    (irq_o)
   );

   // R2: a level pin never reports status away from its active level
   p_level_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense & (pin_i ^ pol)) & raw) == '0);
   // R7: an asserted interrupt implies some enabled pin was raised
   p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(en) != '0));
endmodule

// File: tb/pin_event_detector_bench.sv
module pin_event_detector_bench;
   import ped_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pins = '0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rd;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] m_mode = '0, m_dual = '0, m_pol = '0, m_en = '0, m_lat = '0, m_prev = '0;

   always #5 clk = ~clk;

   pin_event_detector u_pin_event_detector (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pins),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wdata),
      .rd_data_o (rd),
      .irq_o     (irq)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic rd_at(input logic [2:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rd;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic step(input logic [7:0] np, input logic [7:0] clr, input bit chk);
      logic [7:0] rise, fall, hit, raw_pre, raw_post, v;
      logic eirq;
      @(negedge clk);
      pins = np;
      if (clr != 0) begin wr_en = 1'b1; addr = A_CLR; wdata = clr; end
      rise = np & ~m_prev;
      fall = ~np & m_prev;
      hit = ~m_mode & ((m_dual & (rise | fall)) | (~m_dual & m_pol & rise) | (~m_dual & ~m_pol & fall));
      raw_pre = (m_mode & ~(np ^ m_pol)) | (~m_mode & m_lat);
      eirq = |(raw_pre & m_en);
      m_lat = ~m_mode & (hit | (m_lat & ~clr));
      m_prev = np;
      raw_post = (m_mode & ~(np ^ m_pol)) | (~m_mode & m_lat);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (chk) begin
         rd_at(A_RAW, v);
         check(v, raw_post, "R2/R3/R4/R5/R6 raw status");
         rd_at(A_MASK, v);
         check(v, raw_post & m_en, "R7 masked status");
         check({7'd0, irq}, {7'd0, eirq}, "R8 irq");
      end
   endtask

   task automatic cfg(input logic [7:0] mo, input logic [7:0] du, input logic [7:0] po, input logic [7:0] en);
      logic [7:0] v;
      wr(A_SENSE, mo); wr(A_DUAL, du); wr(A_POL, po); wr(A_EN, en);
      m_mode = mo; m_dual = du; m_pol = po; m_en = en;
      step(pins, 8'hFF, 1'b0);
      rd_at(A_SENSE, v); check(v, mo, "R9 sense readback");
      rd_at(A_DUAL, v);  check(v, du, "R9 both-edge readback");
      rd_at(A_POL, v);   check(v, po, "R9 polarity readback");
      rd_at(A_EN, v);    check(v, en, "R9 enable readback");
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [15:0] lf;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd_at(3'(a), v);
         check(v, 8'h00, "R1 reset register value");
      end
      check({7'd0, irq}, 8'h00, "R1 reset irq");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R3 directed: rising edges on all pins, none enabled
      cfg(8'h00, 8'h00, 8'hFF, 8'h00);
      step(8'hFF, 8'h00, 1'b1);
      rd_at(A_RAW, v); check(v, 8'hFF, "R3 rising edges latched");
      // R7: latched although disabled, enabling exposes them
      step(8'hFF, 8'h00, 1'b1);
      check({7'd0, irq}, 8'h00, "R7 disabled pins keep irq low");
      wr(A_EN, 8'h01); m_en = 8'h01;
      rd_at(A_MASK, v); check(v, 8'h01, "R7 pending edge visible on enable");
      step(8'hFF, 8'h00, 1'b1);
      check({7'd0, irq}, 8'h01, "R7 irq raised by pending edge");
      // R5: only bits written 1 clear
      step(8'hFF, 8'h0F, 1'b1);
      rd_at(A_RAW, v); check(v, 8'hF0, "R5 zero bits keep status");
      // R6: edge and clear together
      step(8'h00, 8'h00, 1'b1);
      step(8'h01, 8'hFF, 1'b1);
      rd_at(A_RAW, v); check(v, 8'h01, "R6 edge beats clear");
      rd_at(3'd6, v); check(v, 8'h00, "R9 clear address reads zero");
      rd_at(3'd7, v); check(v, 8'h00, "R9 unused address reads zero");

      // R2 directed: level high on pin 0, low on pin 1
      cfg(8'h03, 8'h00, 8'h01, 8'h03);
      step(8'h01, 8'h00, 1'b1);
      rd_at(A_RAW, v); check(v, 8'h03, "R2 both levels active");
      step(8'h02, 8'h00, 1'b1);
      rd_at(A_RAW, v); check(v, 8'h00, "R2 level status drops");

      // R4 directed: both edges, polarity ignored
      cfg(8'h00, 8'hFF, 8'h55, 8'hFF);
      step(8'h0F, 8'h00, 1'b1);
      step(8'h00, 8'h00, 1'b1);
      rd_at(A_RAW, v); check(v, 8'h0F, "R4 both edges latch");

      // sweep over configuration mixes with pseudo-random pins and clears
      lf = 16'hACE1;
      for (int k = 0; k < 8; k++) begin
         cfg(8'h0F ^ 8'(k * 29), 8'h33 ^ 8'(k * 71), 8'h5A ^ 8'(k * 13), 8'hFF ^ 8'(k * 37));
         for (int s = 0; s < 48; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(pins ^ lf[7:0], (s % 3 == 2) ? lf[15:8] : 8'h00, 1'b1);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule